// File: doc/BRIEF.md
# BCH Error Position Applier

This block applies the bit corrections found by a BCH decoder to one sector held in a byte-wide buffer. After a start strobe it waits for the decoder to raise its decode-done flag, takes a snapshot of the decoder's five status words, and decides from word 0 whether the sector is clean, uncorrectable or correctable. For a correctable sector it walks the reported error positions in order. Each position names one bit: the byte index is the position divided by 8 and the bit index is the position modulo 8. Positions that fall outside the sector data are skipped. Every kept position is fixed by reading the byte, inverting one bit and writing the byte back.

The buffer port follows a synchronous RAM: a read request in one cycle returns data one cycle later. The block finishes with a two-bit result code and a done flag. Both stay set until a clear write, which also drops the snapshot and returns the block to idle for the next sector. If the decode-done flag does not arrive within a set number of cycles, the block finishes with a timeout code. The syndrome and locator computation belongs to the decoder and is not part of this block.

Top module: `bch_fix_applier`

## Requirements
- R1: After reset, done is 0, result is 0 and neither buf_rd_en nor buf_wr_en is asserted.
- R2: After start, the block does nothing until decode_done is high. If decode_done stays low for TMO_CYCLES consecutive waiting cycles, done rises in the TMO_CYCLES-th cycle after the start cycle with result 3 (timeout) and no buffer access.
- R3: If bit 1 (error found) of status word 0 is clear, the result is 0 (clean) and no buffer write occurs, whatever bit 0 holds.
- R4: If bit 1 and bit 0 (uncorrectable) of status word 0 are both set, the result is 2 (bad data) and no buffer write occurs.
- R5: Bits 7:4 of status word 0 give the error count. Position k (k = 0..7) is bits 12:0 of status word k/2+1 for even k and bits 28:16 of that word for odd k. Only the positions with k below the count are considered, so a count above 8 considers all eight.
- R6: A position is applied only if it is below sect_bytes times 8. Otherwise it is skipped with no buffer access.
- R7: An applied position is corrected by a read of byte (position / 8) followed, two cycles after the read request, by a write to the same address of the read byte with bit (position mod 8) inverted. Positions are handled in ascending k, so a repeated position inverts the bit again.
- R8: A correctable sector ends with result 1 (fixed), even when every position was skipped.
- R9: Once done is set, done and result hold and start is ignored until clr. No buffer access occurs while done is set.
- R10: A clr cycle clears done and result to 0 and returns the block to idle from any state, which aborts a pending wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins processing of one sector |
| clr | input | 1 | Clear write: drops done, result and snapshot |
| decode_done | input | 1 | Decoder has finished the sector |
| sect_bytes | input | 11 | Sector data size in bytes |
| status_words | input | 160 | Decoder status words 0..4, word n in bits 32n+31:32n |
| buf_rd_data | input | 8 | Buffer read data, valid one cycle after a read request |
| buf_addr | output | 10 | Buffer byte address |
| buf_rd_en | output | 1 | Buffer read request |
| buf_wr_en | output | 1 | Buffer write request |
| buf_wr_data | output | 8 | Corrected byte to write |
| result | output | 2 | 0 clean, 1 fixed, 2 bad data, 3 timeout |
| done | output | 1 | Sector finished; held until clr |

## Verification
The assertions check the port protocol on every cycle. Each write follows its read two cycles earlier at the same address. Reads and writes never coincide. A write address always lies inside the sector. Done and result stay frozen until clr, clr always empties them, and the buffer is quiet while done is set. Only the bench scenarios can show the decoding behaviour. That covers which fields hold the positions, how the count limits and clamps them, the clean and bad-data priorities, and the exact bit inverted. The scoreboard compares each write address and byte against values computed from a separate buffer model. The bench scenarios also cover the exact cycle of the timeout and a start that arrives while done is set.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;
  typedef enum logic [1:0] {
    RES_CLEAN   = 2'd0,
    RES_FIXED   = 2'd1,
    RES_BADMSG  = 2'd2,
    RES_TIMEOUT = 2'd3
  } fix_res_t;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WAIT,
    S_DECIDE,
    S_SCAN,
    S_READ,
    S_WRITE,
    S_FIN
  } fix_state_t;
endpackage

// File: rtl/bch_pos_unpack.sv
// Splits the packed status words into NPOS error positions.
// Entry k sits in word k/2+1: even k in the low field, odd k at bit 16.
module bch_pos_unpack #(
  parameter int NPOS  = 8,
  parameter int POS_W = 13,
  parameter int NWORD = NPOS / 2 + 1
) (
  input  logic [NWORD*32-1:0] words,
  output logic [NPOS*POS_W-1:0] pos_flat
);
  logic unused_ok;
  assign unused_ok = ^words;

  genvar k;
  generate
    for (k = 0; k < NPOS; k++) begin : g_pos
      assign pos_flat[k*POS_W +: POS_W] = words[(k/2+1)*32 + (k%2)*16 +: POS_W];
    end
  endgenerate
endmodule

// File: rtl/bch_pos_filter.sv
// Marks which entries are inside the count and inside the sector data.
module bch_pos_filter #(
  parameter int NPOS   = 8,
  parameter int POS_W  = 13,
  parameter int CNT_W  = 4,
  parameter int SECT_W = 11
) (
  input  logic [NPOS*POS_W-1:0] pos_flat,
  input  logic [CNT_W-1:0]      err_cnt,
  input  logic [SECT_W-1:0]     sect_bytes,
  output logic [NPOS-1:0]       keep
);
  localparam int LIM_W = SECT_W + 3;
  localparam int CMP_W = (LIM_W > POS_W) ? LIM_W : POS_W;

  logic [CMP_W-1:0] limit_bits;
  assign limit_bits = CMP_W'({sect_bytes, 3'b000});

  genvar k;
  generate
    for (k = 0; k < NPOS; k++) begin : g_keep
      logic [CMP_W-1:0] pos_ext;
      assign pos_ext = CMP_W'(pos_flat[k*POS_W +: POS_W]);
      assign keep[k] = (32'(err_cnt) > 32'(k)) && (pos_ext < limit_bits);
    end
  endgenerate
endmodule

// File: rtl/bch_wait_timer.sv
// Counts cycles while run is high; expired marks the LIMIT-th cycle.
module bch_wait_timer #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (!expired) begin
      cnt <= cnt + CW'(1);
    end
  end

  assign expired = run && (cnt == CW'(LIMIT - 1));
endmodule

// File: rtl/bch_fix_applier.sv
module bch_fix_applier #(
  parameter int NPOS       = 8,
  parameter int POS_W      = 13,
  parameter int CNT_W      = 4,
  parameter int SECT_W     = 11,
  parameter int TMO_CYCLES = 1000
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic                      clr,
  input  logic                      decode_done,
  input  logic [SECT_W-1:0]         sect_bytes,
  input  logic [32*(NPOS/2+1)-1:0]  status_words,
  input  logic [7:0]                buf_rd_data,
  output logic [POS_W-4:0]          buf_addr,
  output logic                      buf_rd_en,
  output logic                      buf_wr_en,
  output logic [7:0]                buf_wr_data,
  output logic [1:0]                result,
  output logic                      done
);
  import bch_fix_pkg::*;

  localparam int NWORD = NPOS / 2 + 1;
  localparam int SEL_W = (NPOS > 1) ? $clog2(NPOS) : 1;
  localparam int IDX_W = SEL_W + 1;

  fix_state_t           state;
  logic [NWORD*32-1:0]  stat_q;
  logic [IDX_W-1:0]     idx;
  logic [SEL_W-1:0]     idx_lo;
  logic [NPOS*POS_W-1:0] pos_flat;
  logic [NPOS-1:0]      keep;
  logic [POS_W-1:0]     cur_pos;
  logic [CNT_W-1:0]     err_cnt;
  logic                 err_found;
  logic                 err_uncorr;
  logic                 scan_end;
  logic                 tmo_hit;

  assign err_uncorr = stat_q[0];
  assign err_found  = stat_q[1];
  assign err_cnt    = stat_q[4 +: CNT_W];

  bch_pos_unpack #(.NPOS(NPOS), .POS_W(POS_W), .NWORD(NWORD)) u_unpack (
    .words    (stat_q),
    .pos_flat (pos_flat)
  );

  bch_pos_filter #(.NPOS(NPOS), .POS_W(POS_W), .CNT_W(CNT_W), .SECT_W(SECT_W)) u_filter (
    .pos_flat   (pos_flat),
    .err_cnt    (err_cnt),
    .sect_bytes (sect_bytes),
    .keep       (keep)
  );

  bch_wait_timer #(.LIMIT(TMO_CYCLES)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run     (state == S_WAIT),
    .expired (tmo_hit)
  );

  assign idx_lo   = idx[SEL_W-1:0];
  assign cur_pos  = pos_flat[idx_lo*POS_W +: POS_W];
  assign scan_end = (idx == IDX_W'(NPOS)) || (32'(idx) >= 32'(err_cnt));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= S_IDLE;
      stat_q      <= '0;
      idx         <= '0;
      buf_addr    <= '0;
      buf_rd_en   <= 1'b0;
      buf_wr_en   <= 1'b0;
      buf_wr_data <= '0;
      result      <= RES_CLEAN;
      done        <= 1'b0;
    end else begin
      buf_rd_en <= 1'b0;
      buf_wr_en <= 1'b0;
      if (clr) begin
        state  <= S_IDLE;
        stat_q <= '0;
        idx    <= '0;
        result <= RES_CLEAN;
        done   <= 1'b0;
      end else begin
        case (state)
          S_IDLE: begin
            if (start) state <= S_WAIT;
          end
          S_WAIT: begin
            if (decode_done) begin
              stat_q <= status_words;
              state  <= S_DECIDE;
            end else if (tmo_hit) begin
              result <= RES_TIMEOUT;
              done   <= 1'b1;
              state  <= S_FIN;
            end
          end
          S_DECIDE: begin
            idx <= '0;
            if (!err_found) begin
              result <= RES_CLEAN;
              done   <= 1'b1;
              state  <= S_FIN;
            end else if (err_uncorr) begin
              result <= RES_BADMSG;
              done   <= 1'b1;
              state  <= S_FIN;
            end else begin
              state <= S_SCAN;
            end
          end
          S_SCAN: begin
            if (scan_end) begin
              result <= RES_FIXED;
              done   <= 1'b1;
              state  <= S_FIN;
            end else if (keep[idx_lo]) begin
              buf_addr  <= cur_pos[POS_W-1:3];
              buf_rd_en <= 1'b1;
              state     <= S_READ;
            end else begin
              idx <= idx + IDX_W'(1);
            end
          end
          S_READ: begin
            state <= S_WRITE;
          end
          S_WRITE: begin
            buf_wr_en   <= 1'b1;
            buf_wr_data <= buf_rd_data ^ (8'd1 << cur_pos[2:0]);
            idx         <= idx + IDX_W'(1);
            state       <= S_SCAN;
          end
          S_FIN: begin
            state <= S_FIN;
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/bch_fix_checker.sv
module bch_fix_checker #(
  parameter int POS_W  = 13,
  parameter int SECT_W = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              clr,
  input logic              done,
  input logic [1:0]        result,
  input logic              buf_rd_en,
  input logic              buf_wr_en,
  input logic [POS_W-4:0]  buf_addr,
  input logic [SECT_W-1:0] sect_bytes
);
  // R7: every write is preceded by a read of the same byte two cycles earlier
  a_r7_write_follows_read: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> ($past(buf_rd_en, 2) && ($past(buf_addr, 2) == buf_addr)));

  // R7: read and write never share a cycle
  a_r7_port_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(buf_rd_en && buf_wr_en));

  // R6: writes stay inside the sector data
  a_r6_write_in_sector: assert property (@(posedge clk) disable iff (rst)
    buf_wr_en |-> (32'(buf_addr) < 32'(sect_bytes)));

  // R9: done and result hold until clear
  a_r9_done_holds: assert property (@(posedge clk) disable iff (rst)
    (done && !clr) |=> (done && $stable(result)));

  // R9: buffer quiet while done
  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (rst)
    done |-> (!buf_rd_en && !buf_wr_en));

  // R10: clear empties done and result
  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!done && (result == 2'd0)));
endmodule

bind bch_fix_applier bch_fix_checker #(.POS_W(POS_W), .SECT_W(SECT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clr        (clr),
  .done       (done),
  .result     (result),
  .buf_rd_en  (buf_rd_en),
  .buf_wr_en  (buf_wr_en),
  .buf_addr   (buf_addr),
  .sect_bytes (sect_bytes)
);

// File: tb/tb_bch_fix_applier.sv
module tb_bch_fix_applier;
  localparam int NPOS   = 8;
  localparam int POS_W  = 13;
  localparam int SECT_W = 11;
  localparam int TMO    = 20;
  localparam int NW     = NPOS / 2 + 1;
  localparam int AW     = POS_W - 3;
  localparam int MEMSZ  = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic clr = 1'b0;
  logic decode_done = 1'b0;
  logic [SECT_W-1:0] sect_bytes = '0;
  logic [NW*32-1:0]  status_words = '0;
  logic [7:0]        buf_rd_data;
  logic [AW-1:0]     buf_addr;
  logic              buf_rd_en, buf_wr_en;
  logic [7:0]        buf_wr_data;
  logic [1:0]        result;
  logic              done;

  always #4 clk = ~clk;

  bch_fix_applier #(.NPOS(NPOS), .POS_W(POS_W), .CNT_W(4), .SECT_W(SECT_W),
                    .TMO_CYCLES(TMO)) dut (
    .clk(clk), .rst(rst), .start(start), .clr(clr), .decode_done(decode_done),
    .sect_bytes(sect_bytes), .status_words(status_words), .buf_rd_data(buf_rd_data),
    .buf_addr(buf_addr), .buf_rd_en(buf_rd_en), .buf_wr_en(buf_wr_en),
    .buf_wr_data(buf_wr_data), .result(result), .done(done)
  );

  // Synchronous buffer model, one cycle read latency
  logic [7:0] mem [MEMSZ];
  logic [7:0] ref_mem [MEMSZ];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= 8'(i * 37 + 11);
    end else begin
      if (buf_rd_en) buf_rd_data <= mem[buf_addr];
      if (buf_wr_en) mem[buf_addr] <= buf_wr_data;
    end
  end

  typedef struct packed {
    logic [AW-1:0] a;
    logic [7:0]    d;
  } wr_item_t;

  wr_item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  int pos_set[NPOS];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Monitor: pops expected writes as the design issues them (R7)
  always @(negedge clk) begin
    if (!rst && buf_wr_en) begin
      wr_item_t it;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected write at address", int'(buf_addr), -1);
      end else begin
        it = exp_q.pop_front();
        chk(buf_addr == it.a, "R7", "write address", int'(buf_addr), int'(it.a));
        chk(buf_wr_data == it.d, "R7", "write data", int'(buf_wr_data), int'(it.d));
      end
    end
  end

  // Driver: builds status, predicts writes and result, runs one sector
  task automatic run_sector(input logic [3:0] cnt, input bit found, input bit uncorr,
                            input int sect, input string tag);
    logic [NW*32-1:0] sw;
    logic [1:0] exp_res;
    int napply;
    int wait_n;
    sw = '0;
    sw[0] = uncorr;
    sw[1] = found;
    sw[7:4] = cnt;
    for (int k = 0; k < NPOS; k++)
      sw[(k/2+1)*32 + (k%2)*16 +: POS_W] = POS_W'(pos_set[k]);
    if (!found) exp_res = 2'd0;
    else if (uncorr) exp_res = 2'd2;
    else begin
      exp_res = 2'd1;
      napply = (int'(cnt) > NPOS) ? NPOS : int'(cnt);
      for (int k = 0; k < napply; k++) begin
        if (pos_set[k] < sect * 8) begin
          int a;
          a = pos_set[k] / 8;
          ref_mem[a] = ref_mem[a] ^ 8'(1 << (pos_set[k] % 8));
          exp_q.push_back('{a: AW'(a), d: ref_mem[a]});
        end
      end
    end
    @(negedge clk);
    status_words = sw;
    sect_bytes = SECT_W'(sect);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    chk(done == 1'b0, "R2", "done before decode_done", int'(done), 0);
    decode_done = 1'b1;
    wait_n = 0;
    while (!done && wait_n < 300) begin
      @(negedge clk);
      wait_n++;
    end
    chk(done == 1'b1, tag, "done raised", int'(done), 1);
    chk(result == exp_res, tag, "result code", int'(result), int'(exp_res));
    chk(exp_q.size() == 0, "R7", "pending expected writes", exp_q.size(), 0);
  endtask

  task automatic clear_sector();
    @(negedge clk);
    clr = 1'b1;
    decode_done = 1'b0;
    @(negedge clk);
    clr = 1'b0;
    chk(done == 1'b0, "R10", "done after clear", int'(done), 0);
    chk(result == 2'd0, "R10", "result after clear", int'(result), 0);
  endtask

  initial begin
    for (int i = 0; i < MEMSZ; i++) ref_mem[i] = 8'(i * 37 + 11);
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(result == 2'd0, "R1", "result after reset", int'(result), 0);
    chk(!buf_rd_en && !buf_wr_en, "R1", "buffer access after reset",
        int'({buf_rd_en, buf_wr_en}), 0);

    // R3: error-found clear wins over uncorrectable bit
    pos_set = '{5, 6, 7, 8, 9, 10, 11, 12};
    run_sector(4'd3, 1'b0, 1'b1, 512, "R3");
    clear_sector();

    // R4: uncorrectable
    pos_set = '{20, 21, 22, 23, 24, 25, 26, 27};
    run_sector(4'd2, 1'b1, 1'b1, 512, "R4");
    clear_sector();

    // R5/R6: count 3, third position beyond sector, rest beyond count
    pos_set = '{0, 4095, 5000, 17, 18, 19, 20, 21};
    run_sector(4'd3, 1'b1, 1'b0, 512, "R5");
    clear_sector();

    // R5: all eight fields used
    pos_set = '{9, 1000, 2047, 3000, 8, 4000, 12, 4094};
    run_sector(4'd8, 1'b1, 1'b0, 512, "R5");
    clear_sector();

    // R5: count above eight clamps to eight
    pos_set = '{1, 2, 3, 4, 5, 6, 7, 4093};
    run_sector(4'd15, 1'b1, 1'b0, 512, "R5");
    clear_sector();

    // R7: repeated position inverts again
    pos_set = '{100, 100, 0, 0, 0, 0, 0, 0};
    run_sector(4'd2, 1'b1, 1'b0, 512, "R7");
    clear_sector();

    // R6: small sector, limit 128 bits
    pos_set = '{127, 128, 8191, 0, 0, 0, 0, 0};
    run_sector(4'd3, 1'b1, 1'b0, 16, "R6");

    // R9: start ignored while done
    @(negedge clk);
    start = 1'b1;
    decode_done = 1'b0;
    status_words = '0;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R9", "done held after start", int'(done), 1);
    chk(result == 2'd1, "R9", "result held after start", int'(result), 1);
    clear_sector();

    // R8: every position skipped still reports fixed
    pos_set = '{5000, 6000, 0, 0, 0, 0, 0, 0};
    run_sector(4'd2, 1'b1, 1'b0, 512, "R8");
    clear_sector();

    // R2: timeout on exact cycle
    @(negedge clk);
    status_words = '0;
    start = 1'b1;
    @(posedge clk);
    #1 start = 1'b0;
    repeat (TMO - 1) @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R2", "done one cycle before timeout", int'(done), 0);
    @(negedge clk);
    chk(done == 1'b1, "R2", "done at timeout", int'(done), 1);
    chk(result == 2'd3, "R2", "timeout code", int'(result), 3);
    clear_sector();

    // R10: clear aborts a pending wait
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    repeat (TMO + 5) @(negedge clk);
    chk(done == 1'b0, "R10", "done after aborted wait", int'(done), 0);
    chk(result == 2'd0, "R10", "result after aborted wait", int'(result), 0);

    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule